// File: doc/BRIEF.md
# Character LCD Nibble Transfer Engine

This block writes one byte into a character display controller over a four-wire data bus. A user asserts `start` for one cycle with a byte and a register-select bit. The engine then reads the display's status until it reports ready. Only after that does it write the byte as two nibbles, giving each nibble its own enable strobe. It signals completion with a single-cycle `done` pulse.

The status read is two enable strobes with the select line low and the direction line high. While it runs, the engine releases the data lines. The busy bit is the top bit of the first nibble it reads. The second nibble is always clocked out and then discarded. If the display is still busy, the engine idles for a programmable delay and then reads status again. A dead cycle separates releasing the bus from driving it. Between transfers the data lines are driven low.

Top module: `lcd_nibble_xfer`

## Requirements
- R1: After reset the engine is idle with `lcd_e`, `lcd_rw`, `lcd_rs` and `done` low, `lcd_d_oe` high and `lcd_d_out` equal to 0.
- R2: Every transfer begins with a status poll of exactly two enable strobes, with `lcd_rs`=0, `lcd_rw`=1 and `lcd_d_oe`=0.
- R3: Busy is taken from `lcd_d_in[3]` of the first status strobe only. The value on `lcd_d_in[3]` during the second strobe has no effect on whether the poll repeats.
- R4: While busy reads 1, the engine holds enable low for `E_LOW + RETRY_WAIT` cycles after the second status strobe and then repeats the two-strobe poll.
- R5: Once busy reads 0, the byte is written as two strobes with `lcd_rw`=0 and `lcd_rs` equal to the `rs_sel` captured at start. The first strobe carries byte bits [7:4] on `lcd_d_out` and the second carries bits [3:0].
- R6: Each enable strobe stays high for exactly `E_HIGH` cycles. `lcd_rs`, `lcd_rw` and `lcd_d_out` are stable while it is high. Read data is sampled in the last high cycle.
- R7: Enable low time is `E_LOW` cycles between the two nibbles of a poll, `E_LOW+2` cycles from the poll to the first write nibble and `E_LOW+1` between the two write nibbles. The cycle on which `lcd_rw` falls has `lcd_d_oe` low, and the bus is driven to zero again after the transfer.
- R8: `done` is high for exactly one cycle, after the second write strobe has ended.
- R9: A `start` pulse while a transfer is in progress is ignored. It produces no extra strobes and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| rs_sel | input | 1 | Register select for the write: 0 instruction, 1 character data |
| wr_byte | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display direction, 1 = read |
| lcd_e | output | 1 | Display enable strobe |
| lcd_d_out | output | 4 | Data nibble driven to the display |
| lcd_d_oe | output | 1 | Data bus output enable |
| lcd_d_in | input | 4 | Data nibble read from the display |

## Verification
Bytes with different nibble patterns (A5, 3C, 81, 00, FF) are sent with both select values. This separates upper from lower nibble order and shows that select follows the request. A display model reports busy for zero, one or two polls. It always returns a set top bit on the second nibble, which shows whether the engine reads busy from the wrong nibble. Each strobe's width and the low gap before it are compared with the expected value for its position in the sequence. One transfer receives a second start mid-flight to show that the request is dropped.

// File: rtl/lcd_nibble_xfer.sv
module lcd_nibble_xfer #(
  parameter int E_HIGH     = 8,
  parameter int E_LOW      = 4,
  parameter int RETRY_WAIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rs_sel,
  input  logic [7:0] wr_byte,
  output logic       done,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [3:0] lcd_d_out,
  output logic       lcd_d_oe,
  input  logic [3:0] lcd_d_in
);
  localparam int M1   = (E_HIGH > E_LOW) ? E_HIGH : E_LOW;
  localparam int CMAX = (M1 > RETRY_WAIT) ? M1 : RETRY_WAIT;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RDSET, S_RDHI, S_RDLO, S_RETRY, S_TURN, S_WRSET, S_WRHI, S_WRLO
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          half, busy, rs_q;
  logic [7:0]    byte_q;

  wire last_hi = (cnt == CW'(E_HIGH - 1));
  wire last_lo = (cnt == CW'(E_LOW - 1));
  wire last_rt = (cnt == CW'(RETRY_WAIT - 1));
  wire wr_ph   = (st == S_WRSET) || (st == S_WRHI) || (st == S_WRLO);

  assign lcd_e     = (st == S_RDHI) || (st == S_WRHI);
  assign lcd_rw    = (st == S_RDSET) || (st == S_RDHI) || (st == S_RDLO) || (st == S_RETRY);
  assign lcd_rs    = (wr_ph || st == S_TURN) ? rs_q : 1'b0;
  assign lcd_d_oe  = wr_ph || (st == S_IDLE);
  assign lcd_d_out = wr_ph ? (half ? byte_q[3:0] : byte_q[7:4]) : 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      half   <= 1'b0;
      busy   <= 1'b0;
      rs_q   <= 1'b0;
      byte_q <= 8'h00;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          byte_q <= wr_byte;
          rs_q   <= rs_sel;
          half   <= 1'b0;
          cnt    <= '0;
          st     <= S_RDSET;
        end
        S_RDSET: begin cnt <= '0; st <= S_RDHI; end
        S_RDHI: if (last_hi) begin
          cnt <= '0;
          if (!half) busy <= lcd_d_in[3];
          st <= S_RDLO;
        end else cnt <= cnt + 1'b1;
        S_RDLO: if (last_lo) begin
          cnt <= '0;
          if (!half) begin half <= 1'b1; st <= S_RDHI; end
          else begin half <= 1'b0; st <= busy ? S_RETRY : S_TURN; end
        end else cnt <= cnt + 1'b1;
        S_RETRY: if (last_rt) begin cnt <= '0; st <= S_RDHI; end
                 else cnt <= cnt + 1'b1;
        S_TURN:  st <= S_WRSET;
        S_WRSET: begin cnt <= '0; st <= S_WRHI; end
        S_WRHI: if (last_hi) begin cnt <= '0; st <= S_WRLO; end
                else cnt <= cnt + 1'b1;
        S_WRLO: if (last_lo) begin
          cnt <= '0;
          if (!half) begin half <= 1'b1; st <= S_WRSET; end
          else begin half <= 1'b0; done <= 1'b1; st <= S_IDLE; end
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW:0] e_run;
  always_ff @(posedge clk) begin
    if (!rst_n)     e_run <= '0;
    else if (lcd_e) e_run <= e_run + 1'b1;
    else            e_run <= '0;
  end

  a_r6_enable_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_e && e_run != '0) |-> (e_run == (CW+1)'(E_HIGH)));
  a_r6_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_d_out) && $stable(lcd_rs) && $stable(lcd_rw)));
  a_r2_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw |-> (!lcd_d_oe && !lcd_rs));
  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_rw) |-> !lcd_d_oe);
  a_r7_drive_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_d_oe) |-> $past(!lcd_rw));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!lcd_e && lcd_d_oe && lcd_d_out == 4'h0));
endmodule

// File: tb/tb_lcd_nibble_xfer.sv
module tb_lcd_nibble_xfer;
  localparam int E_HIGH = 8, E_LOW = 4, RETRY_WAIT = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rs_sel = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic done, lcd_rs, lcd_rw, lcd_e, lcd_d_oe;
  logic [3:0] lcd_d_out, lcd_d_in;

  always #5 clk = ~clk;

  lcd_nibble_xfer #(.E_HIGH(E_HIGH), .E_LOW(E_LOW), .RETRY_WAIT(RETRY_WAIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rs_sel(rs_sel), .wr_byte(wr_byte),
    .done(done), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in));

  typedef struct { bit rd; bit rs; logic [3:0] nib; int gap; } ev_t;
  ev_t exp_q[$];
  int n_chk = 0, n_err = 0;
  int rd2_total = 0, busy_until = 0, done_cnt = 0;
  bit rd_phase = 1'b0;

  // First status nibble carries busy in bit 3; second nibble always has bit 3 set (R3).
  assign lcd_d_in = rd_phase ? 4'hF : {(rd2_total < busy_until), 3'b010};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int hi_len = 0, lo_len = -1, cur_gap = 0;
  bit s_rw, s_rs, s_oe, unstable;
  logic [3:0] s_d;

  always @(negedge clk) begin
    if (!rst_n) begin
      hi_len = 0; lo_len = -1;
    end else begin
      if (done) done_cnt++;
      if (lcd_e) begin
        if (hi_len == 0) begin
          cur_gap = lo_len; s_rw = lcd_rw; s_rs = lcd_rs; s_d = lcd_d_out;
          s_oe = lcd_d_oe; unstable = 1'b0;
        end else if (lcd_rw != s_rw || lcd_rs != s_rs || lcd_d_out != s_d) unstable = 1'b1;
        hi_len++;
      end else begin
        if (hi_len > 0) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected strobe", 1, 0);
          end else begin
            ev_t e;
            e = exp_q.pop_front();
            chk(s_rw == e.rd, "R2/R5 strobe direction", s_rw, e.rd);
            chk(s_rs == e.rs, "R2/R5 register select", s_rs, e.rs);
            chk(s_oe == !e.rd, "R2/R7 bus drive", s_oe, !e.rd);
            if (!e.rd) chk(s_d == e.nib, "R5 write nibble", s_d, e.nib);
            chk(hi_len == E_HIGH, "R6 enable width", hi_len, E_HIGH);
            chk(!unstable, "R6 stable during strobe", unstable, 0);
            if (e.gap >= 0) chk(cur_gap == e.gap, "R4/R7 low gap", cur_gap, e.gap);
            if (s_rw) begin
              if (rd_phase) rd2_total++;
              rd_phase = ~rd_phase;
            end
          end
          hi_len = 0; lo_len = 0;
        end
        if (lo_len >= 0) lo_len++;
      end
    end
  end

  task automatic xfer(input logic [7:0] b, input bit rs, input int nbusy, input bit poke);
    ev_t e;
    int d0, t;
    busy_until = rd2_total + nbusy;
    for (int p = 0; p <= nbusy; p++) begin
      e = '{1'b1, 1'b0, 4'h0, (p == 0) ? -1 : E_LOW + RETRY_WAIT}; exp_q.push_back(e);
      e = '{1'b1, 1'b0, 4'h0, E_LOW}; exp_q.push_back(e);
    end
    e = '{1'b0, rs, b[7:4], E_LOW + 2}; exp_q.push_back(e);
    e = '{1'b0, rs, b[3:0], E_LOW + 1}; exp_q.push_back(e);
    d0 = done_cnt;
    @(negedge clk); start = 1'b1; wr_byte = b; rs_sel = rs;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; wr_byte = ~b; rs_sel = ~rs;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R8 done seen", done, 1);
    chk(exp_q.size() == 0, "R5/R8 all strobes before done", exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    chk(lcd_d_oe && lcd_d_out == 4'h0 && !lcd_rw && !lcd_e, "R7 bus back to driven zero",
        {lcd_d_oe, lcd_d_out, lcd_rw, lcd_e}, 7'b1000000);
    repeat (60) @(negedge clk);
    chk(done_cnt - d0 == 1, "R9 single done per transfer", done_cnt - d0, 1);
    chk(exp_q.size() == 0, "R9 no leftover strobes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!lcd_e && !lcd_rw && !lcd_rs && !done, "R1 reset controls low",
        {lcd_e, lcd_rw, lcd_rs, done}, 0);
    chk(lcd_d_oe && lcd_d_out == 4'h0, "R1 reset bus driven zero", {lcd_d_oe, lcd_d_out}, 16);
    xfer(8'hA5, 1'b1, 0, 1'b0);
    xfer(8'h3C, 1'b0, 0, 1'b0);
    xfer(8'h81, 1'b1, 2, 1'b0);   // R4 two busy polls
    xfer(8'h00, 1'b0, 1, 1'b0);   // R3 second nibble bit3 ignored
    xfer(8'hFF, 1'b1, 1, 1'b1);   // R9 start during transfer
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule